// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block is the digital core of a system reset supervisor. It runs on a free-running clock and takes two inputs. The first is a flag that says the supply is above its trip threshold. This flag comes from an external comparator and is already synchronised. The second is the SPI chip-select line of the host. From these the block drives a single reset output, whose polarity is a build parameter.

Reset is held at power-up and for as long as the supply flag is low. After the supply recovers, reset is held for a further settle period before it releases. A watchdog watches chip-select and expects a falling edge from time to time. If chip-select stays at either level for longer than the selected timeout, reset is asserted again. Reset is then held for the same settle period as after a supply fault.

A two-bit code selects the watchdog timeout or turns the watchdog off. Writes to the code can be blocked by a lock-enable bit together with an active-low protect pin. All times are given in milliseconds and converted to clock-cycle counts from a clock-frequency parameter.

Top module: `supply_wdt_supervisor`

## Requirements
- R1: After `rst_ni` is released, reset is asserted and `wdt_code_o` equals the initial code, which defaults to 2'b00.
- R2: While `supply_ok_i` is low, reset is asserted. Reset is asserted from the first clock edge that samples the flag low.
- R3: Reset releases at the clock edge where `supply_ok_i` has been sampled high on HOLD consecutive edges, and not before. HOLD = CLK_HZ × HOLD_MS / 1000, with a default of 200 ms.
- R4: A low sample of `supply_ok_i` during the hold period restarts the hold count from zero.
- R5: With ACTIVE_HIGH = 0, `reset_o` is low when reset is asserted. With ACTIVE_HIGH = 1, `reset_o` is high when reset is asserted.
- R6: When reset is released and no chip-select falling edge arrives, reset is asserted again at the LIMIT-th edge after release. The code sets LIMIT as follows: 2'b00 gives 1400 ms, 2'b01 gives 600 ms and 2'b10 gives 200 ms, each converted to cycles as in R3.
- R7: A falling edge on `spi_cs_ni` restarts the watchdog count, so the next timeout falls LIMIT edges after the edge that samples the kick. Rising edges and steady levels do not restart the count.
- R8: Code 2'b11 disables the watchdog, and reset stays released for any length of chip-select inactivity.
- R9: A watchdog timeout holds reset for HOLD cycles. Reset is then released and the watchdog count starts again from zero.
- R10: A write strobe loads `wdt_code_i` into the code on the next edge. The write is ignored when `lock_en_i` = 1 and `wp_ni` = 0. The code is always visible on `wdt_code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset of the logic |
| supply_ok_i | input | 1 | Synchronised flag, high when the supply is above trip |
| spi_cs_ni | input | 1 | Host chip-select level; falling edges kick the watchdog |
| wdt_code_i | input | 2 | New watchdog timeout code |
| wdt_code_we_i | input | 1 | Write strobe for the timeout code |
| lock_en_i | input | 1 | Lock-enable bit for the timeout code |
| wp_ni | input | 1 | Active-low protect pin; blocks writes when the lock is enabled |
| wdt_code_o | output | 2 | Current timeout code |
| reset_o | output | 1 | Reset output, polarity set by ACTIVE_HIGH |

## Verification
The bench uses a 100 Hz clock-frequency setting, so that HOLD is 20 cycles and the timeouts are 140, 60 and 20 cycles. It sweeps every timeout code and probes each hold and timeout window one edge before and at the expected edge, which exposes off-by-one errors in both counters.

Chip-select is driven in several patterns:
- held steady high;
- held steady low;
- a single falling edge;
- a single rising edge;
- periodic toggling faster than the timeout.

These patterns separate a count restart caused by a falling edge from one caused by any edge, or from no restart at all. Supply glitches during the hold period check the restart of the hold count. A locked write followed by an unlocked one shows that the protect gating depends on both inputs.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    WDT_LONG  = 2'b00,
    WDT_MID   = 2'b01,
    WDT_SHORT = 2'b10,
    WDT_OFF   = 2'b11
  } wdt_code_e;

  function automatic longint unsigned ms_to_cyc(longint unsigned hz, longint unsigned ms);
    return (hz * ms) / 1000;
  endfunction

  function automatic longint unsigned max3(longint unsigned a, longint unsigned b,
                                           longint unsigned c);
    longint unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sup_wdt_cfg.sv
module sup_wdt_cfg #(
  parameter logic [1:0] CODE_INIT = 2'b00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] code_i,
  input  logic       lock_en_i,
  input  logic       wp_ni,
  output logic [1:0] code_o
);

  logic [1:0] code_q;
  logic       locked;

  assign locked = lock_en_i & ~wp_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               code_q <= CODE_INIT;
    else if (we_i && !locked)  code_q <= code_i;
  end

  assign code_o = code_q;

  // R10: a locked write never changes the code
  a_r10_locked_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_en_i && !wp_ni) |=> $stable(code_q))
    else $error("a_r10_locked_stable");

endmodule

// File: rtl/sup_wdt_core.sv
module sup_wdt_core
  import sup_pkg::*;
#(
  parameter int unsigned T_LONG  = 140,
  parameter int unsigned T_MID   = 60,
  parameter int unsigned T_SHORT = 20,
  parameter int unsigned CNT_W   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic       cs_ni,
  input  logic [1:0] code_i,
  output logic       fire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             cs_q;
  logic             kick;
  logic             en;

  always_comb begin
    case (code_i)
      WDT_LONG:  limit = CNT_W'(T_LONG);
      WDT_MID:   limit = CNT_W'(T_MID);
      WDT_SHORT: limit = CNT_W'(T_SHORT);
      default:   limit = '0;
    endcase
  end

  assign en   = !hold_i && (code_i != WDT_OFF);
  assign kick = cs_q & ~cs_ni;
  // >= tolerates a code change that shortens the window mid-count
  assign fire_o = en && !kick && (cnt_q >= limit - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      cs_q <= cs_ni;
      if (!en || kick || fire_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R7: a falling chip-select edge restarts the count
  a_r7_kick_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && cs_q && !cs_ni) |=> (cnt_q == '0))
    else $error("a_r7_kick_restarts");

  // R8: disabled code never produces a timeout
  a_r8_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == WDT_OFF) |-> !fire_o)
    else $error("a_r8_off_silent");

  // R9: no timeout while reset is being held
  a_r9_quiet_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !fire_o)
    else $error("a_r9_quiet_in_hold");

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int unsigned HOLD_CYC = 20,
  localparam int unsigned HOLD_W  = $clog2(HOLD_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic restart_i,
  output logic hold_o
);

  logic              hold_q;
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (!supply_ok_i || restart_i) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q) begin
      if (cnt_q == HOLD_W'(HOLD_CYC - 1)) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + HOLD_W'(1);
      end
    end
  end

  assign hold_o = hold_q;

  // R2: low supply forces hold on the next cycle
  a_r2_low_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> hold_q)
    else $error("a_r2_low_holds");

  // R3: release only follows a good-supply sample
  a_r3_release_on_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> $past(supply_ok_i))
    else $error("a_r3_release_on_good");

  // R4: a low sample discards accumulated hold time
  a_r4_count_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (cnt_q == '0))
    else $error("a_r4_count_cleared");

endmodule

// File: rtl/supply_wdt_supervisor.sv
module supply_wdt_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 50_000_000,
  parameter int unsigned HOLD_MS       = 200,
  parameter int unsigned TMO_LONG_MS   = 1400,
  parameter int unsigned TMO_MID_MS    = 600,
  parameter int unsigned TMO_SHORT_MS  = 200,
  parameter bit          ACTIVE_HIGH   = 1'b0,
  parameter logic [1:0]  WDT_CODE_INIT = 2'b00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       spi_cs_ni,
  input  logic [1:0] wdt_code_i,
  input  logic       wdt_code_we_i,
  input  logic       lock_en_i,
  input  logic       wp_ni,
  output logic [1:0] wdt_code_o,
  output logic       reset_o
);

  localparam int unsigned HOLD_CYC = 32'(ms_to_cyc(CLK_HZ, HOLD_MS));
  localparam int unsigned T_LONG   = 32'(ms_to_cyc(CLK_HZ, TMO_LONG_MS));
  localparam int unsigned T_MID    = 32'(ms_to_cyc(CLK_HZ, TMO_MID_MS));
  localparam int unsigned T_SHORT  = 32'(ms_to_cyc(CLK_HZ, TMO_SHORT_MS));
  localparam int unsigned T_MAX    = 32'(max3(T_LONG, T_MID, T_SHORT));
  localparam int unsigned WDT_W    = $clog2(T_MAX + 1);

  logic [1:0] code;
  logic       hold;
  logic       wdt_fire;

  sup_wdt_cfg #(
    .CODE_INIT(WDT_CODE_INIT)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wdt_code_we_i),
    .code_i    (wdt_code_i),
    .lock_en_i (lock_en_i),
    .wp_ni     (wp_ni),
    .code_o    (code)
  );

  sup_wdt_core #(
    .T_LONG  (T_LONG),
    .T_MID   (T_MID),
    .T_SHORT (T_SHORT),
    .CNT_W   (WDT_W)
  ) u_wdt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .cs_ni  (spi_cs_ni),
    .code_i (code),
    .fire_o (wdt_fire)
  );

  sup_hold_timer #(
    .HOLD_CYC(HOLD_CYC)
  ) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .restart_i   (wdt_fire),
    .hold_o      (hold)
  );

  assign wdt_code_o = code;

  if (ACTIVE_HIGH) begin : g_pol_hi
    assign reset_o = hold;
  end else begin : g_pol_lo
    assign reset_o = ~hold;
  end

  // R9: a timeout re-enters the hold period
  a_r9_fire_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_fire |=> hold)
    else $error("a_r9_fire_holds");

endmodule

// File: tb/supply_wdt_supervisor_test.sv
module supply_wdt_supervisor_test;

  localparam int CLK_HZ = 100;
  localparam int HOLD   = CLK_HZ * 200 / 1000;

  function automatic int lim(int c);
    case (c)
      0:       return CLK_HZ * 1400 / 1000;
      1:       return CLK_HZ * 600 / 1000;
      default: return CLK_HZ * 200 / 1000;
    endcase
  endfunction

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok;
  logic       cs_n;
  logic [1:0] code_in;
  logic       code_we;
  logic       lock_en;
  logic       wp_n;
  logic [1:0] code_lo, code_hi;
  logic       rst_lo, rst_hi;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  supply_wdt_supervisor #(.CLK_HZ(CLK_HZ), .ACTIVE_HIGH(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .spi_cs_ni(cs_n),
    .wdt_code_i(code_in), .wdt_code_we_i(code_we), .lock_en_i(lock_en),
    .wp_ni(wp_n), .wdt_code_o(code_lo), .reset_o(rst_lo));

  supply_wdt_supervisor #(.CLK_HZ(CLK_HZ), .ACTIVE_HIGH(1'b1)) uut_hi (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .spi_cs_ni(cs_n),
    .wdt_code_i(code_in), .wdt_code_we_i(code_we), .lock_en_i(lock_en),
    .wp_ni(wp_n), .wdt_code_o(code_hi), .reset_o(rst_hi));

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // checks both polarities (R5) against the expected asserted state
  task automatic chk_rst(bit exp, string tag);
    total++;
    if (rst_lo !== ~exp || rst_hi !== exp) begin
      bad++;
      $display("FAIL %s: reset_o low-variant=%b high-variant=%b expected asserted=%b",
               tag, rst_lo, rst_hi, exp);
    end
  endtask

  task automatic chk_code(logic [1:0] exp, string tag);
    total++;
    if (code_lo !== exp || code_hi !== exp) begin
      bad++;
      $display("FAIL %s: wdt_code_o=%b expected %b", tag, code_lo, exp);
    end
  endtask

  task automatic wr(logic [1:0] c);
    code_in = c;
    code_we = 1'b1;
    step(1);
    code_we = 1'b0;
  endtask

  task automatic expect_fire(int l, string tag);
    step(l - 1);
    chk_rst(1'b0, tag);
    step(1);
    chk_rst(1'b1, tag);
  endtask

  task automatic expect_hold(int used, string tag);
    step(HOLD - 1 - used);
    chk_rst(1'b1, tag);
    step(1);
    chk_rst(1'b0, tag);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit seen;
    rst_n = 1'b0; supply_ok = 1'b0; cs_n = 1'b1; code_in = 2'b00;
    code_we = 1'b0; lock_en = 1'b0; wp_n = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(5);
    chk_rst(1'b1, "R1 reset after power-up");
    chk_code(2'b00, "R1 initial code");
    step(10);
    chk_rst(1'b1, "R2 supply low");

    supply_ok = 1'b1;
    expect_hold(0, "R3 hold window");
    chk_rst(1'b0, "R5 polarity released");

    supply_ok = 1'b0;
    step(1);
    chk_rst(1'b1, "R2 brownout");
    supply_ok = 1'b1;
    step(10);
    chk_rst(1'b1, "R4 partial hold");
    supply_ok = 1'b0;
    step(2);
    chk_rst(1'b1, "R4 glitch");
    supply_ok = 1'b1;
    expect_hold(0, "R4 hold restarted");

    expect_fire(lim(0), "R6 code 00");
    expect_hold(0, "R9 hold after timeout");
    expect_fire(lim(0), "R9 count restarted");

    for (int c = 1; c <= 2; c++) begin
      wr(2'(c));
      expect_hold(1, "R9 hold with write");
      chk_code(2'(c), "R10 write accepted");
      expect_fire(lim(c), "R6 code sweep");
    end
    expect_hold(0, "R9");

    // code 10 (20 cycles): single falling edge
    step(10);
    cs_n = 1'b0;
    step(lim(2));
    chk_rst(1'b0, "R7 falling edge restarts count");
    step(1);
    chk_rst(1'b1, "R7 steady low times out");
    expect_hold(0, "R9");

    // rising edge must not restart
    step(5);
    cs_n = 1'b1;
    step(lim(2) - 6);
    chk_rst(1'b0, "R7 before timeout");
    step(1);
    chk_rst(1'b1, "R7 rising edge ignored");
    expect_hold(0, "R9");

    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      cs_n = ~cs_n;
      for (int k = 0; k < 4; k++) begin
        step(1);
        if (rst_hi !== 1'b0) seen = 1'b1;
      end
    end
    total++;
    if (seen) begin
      bad++;
      $display("FAIL R7 periodic kicks: reset seen asserted=1 expected 0");
    end

    cs_n = 1'b1;
    wr(2'b11);
    chk_code(2'b11, "R8 disable code");
    step(400);
    chk_rst(1'b0, "R8 watchdog off");

    lock_en = 1'b1; wp_n = 1'b0;
    wr(2'b00);
    chk_code(2'b11, "R10 locked write ignored");
    step(200);
    chk_rst(1'b0, "R10 locked, watchdog still off");

    wp_n = 1'b1;
    wr(2'b10);
    chk_code(2'b10, "R10 lock enable alone does not block");
    expect_fire(lim(2), "R10 new code effective");
    expect_hold(0, "R9");

    lock_en = 1'b0; wp_n = 1'b0;
    wr(2'b01);
    chk_code(2'b01, "R10 pin alone does not block");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule